// File: doc/BRIEF.md
# Per-Core Compare Timer

This block gives one processor core an event timer built on a shared 64-bit
system count that always counts up. Software programs a 64-bit compare value,
either as an absolute number or as a signed 32-bit distance from the current
count. A sticky condition flag is set once the count has reached that value,
and a level interrupt leaves the block when the flag, the enable bit and a
clear mask bit all agree.

Registers are reached through a small synchronous port. It has a 4-bit index,
64-bit write data with a write strobe, and read data that follows the index
within the same cycle. Besides the comparator, the port holds a counter
frequency word and a 32-bit scratch word for the kernel. While the frequency
word is zero, the block treats the count as zero.

Top module: `percore_cmp_timer`

## Requirements
- R1: A clock edge with `rst_n` low clears the compare value, the control bits and the kernel word. It loads the frequency word with 0x01800000. `irq` is low afterwards.
- R2: Index 5 is control. Bit 0 is enable, bit 1 is mask and bit 2 is the condition status. A write there changes only bits 0 and 1. Bits 63:3 read as zero.
- R3: The status bit becomes 1 on the edge after the count is found greater than or equal to the compare value, whether or not the timer is enabled. Once set, it stays set until the compare value is rewritten.
- R4: Index 3 reads and writes the absolute compare value. A write sets status on the next edge to the result of comparing the current count with the new value: 1 if count ≥ new value, else 0.
- R5: A write to index 4 sets the compare value to the current count plus the low 32 bits of the write data, sign-extended to 64 bits. Status is then evaluated as in R4.
- R6: A read of index 4 returns the low 32 bits of (compare value − count), zero-extended to 64 bits.
- R7: `irq` equals status AND enable AND NOT mask. It falls in the same cycle that any of those terms becomes false.
- R8: Index 2 reads the count. A write to index 2 has no effect.
- R9: Index 0 holds the 32-bit frequency word; a write takes data bits 31:0. While that word is zero, the count reads as zero and the comparator uses zero.
- R10: Indices 6 to 15 read as zero, and writes to them have no effect.
- R11: Index 1 is a plain 32-bit read/write kernel word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sys_count | input | 64 | Shared up-counting system count |
| reg_addr | input | 4 | Register index |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data for `reg_addr`, same cycle |
| irq | output | 1 | Level timer interrupt |

## Verification
Two things can happen in the same cycle. A rewrite of the compare value, absolute or relative, can land on the cycle in which the running count meets the old value. A frequency write can also land on the cycle the comparator samples the count. The bench provokes both cases by writing compare values equal to, one above, and one below the count at the write edge, and by negative relative distances. It also zeroes the frequency while the comparator is armed. A behavioural model rebuilds status, compare and interrupt from the register rules alone, and every cycle it compares the model against the read data and `irq`. This shows that the write wins over the old sticky flag, and that the count used on that edge is the one gated by the frequency word from before the write.

// File: rtl/timer_pkg.sv
// Shared constants for the per-core compare timer.
// Assumes a 4-bit register index; the index values below are the programming model.
package timer_pkg;
    localparam int CNT_W  = 64;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 4;
    localparam logic [WORD_W-1:0] FREQ_RESET = 32'h0180_0000;

    typedef enum logic [ADDR_W-1:0] {
        IDX_FREQ  = 4'd0,
        IDX_KWORD = 4'd1,
        IDX_COUNT = 4'd2,
        IDX_CMP   = 4'd3,
        IDX_REL   = 4'd4,
        IDX_CTRL  = 4'd5
    } reg_idx_e;
endpackage

// File: rtl/tmr_count_view.sv
// Presents the count the timer uses: zero while the frequency word is zero.
// Assumes the system count is already synchronous to clk.
module tmr_count_view #(
    parameter int CW = 64,
    parameter int FW = 32
) (
    input  logic [FW-1:0] freq,
    input  logic [CW-1:0] sys_count,
    output logic [CW-1:0] cnt
);
    // gate the shared count with the frequency-programmed condition
    always_comb begin
        cnt = (freq == '0) ? '0 : sys_count;
    end
endmodule

// File: rtl/tmr_compare.sv
// Holds the 64-bit compare value and the sticky condition status.
// Assumes at most one of ld_abs/ld_rel is high per cycle.
module tmr_compare #(
    parameter int CW = 64,
    parameter int RW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] cnt,
    input  logic          ld_abs,
    input  logic          ld_rel,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] cmp_q,
    output logic          status_q,
    output logic [RW-1:0] rel_view
);
    localparam int EXT_W = CW - RW;

    logic [CW-1:0] cmp_next;
    logic [CW-1:0] diff;

    // choose the compare value that a write would install
    always_comb begin
        if (ld_rel)
            cmp_next = cnt + {{EXT_W{wdata[RW-1]}}, wdata[RW-1:0]};
        else
            cmp_next = wdata;
    end

    // compare register plus sticky status, rewritten on any compare load
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q    <= '0;
            status_q <= 1'b0;
        end else if (ld_abs || ld_rel) begin
            cmp_q    <= cmp_next;
            status_q <= (cnt >= cmp_next);
        end else begin
            status_q <= status_q | (cnt >= cmp_q);
        end
    end

    // relative view: distance from the count to the compare value
    always_comb begin
        diff     = cmp_q - cnt;
        rel_view = diff[RW-1:0];
    end
endmodule

// File: rtl/tmr_ctrl_regs.sv
// Frequency word, kernel scratch word and the enable/mask control bits.
// Assumes writes arrive as single-cycle strobes already decoded by index.
module tmr_ctrl_regs #(
    parameter int FW = 32,
    parameter logic [FW-1:0] FREQ_INIT = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_freq,
    input  logic          wr_kword,
    input  logic          wr_ctrl,
    input  logic [FW-1:0] wdata,
    output logic [FW-1:0] freq_q,
    output logic [FW-1:0] kword_q,
    output logic          en_q,
    output logic          mask_q
);
    // software-visible configuration state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q  <= FREQ_INIT;
            kword_q <= '0;
            en_q    <= 1'b0;
            mask_q  <= 1'b0;
        end else begin
            if (wr_freq)  freq_q  <= wdata;
            if (wr_kword) kword_q <= wdata;
            if (wr_ctrl) begin
                en_q   <= wdata[0];
                mask_q <= wdata[1];
            end
        end
    end
endmodule

// File: rtl/percore_cmp_timer.sv
// Per-core compare timer: register port, count gating, comparator and interrupt.
// Assumes sys_count is synchronous to clk; read data is combinational on reg_addr.
module percore_cmp_timer
    import timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  sys_count,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [CNT_W-1:0]  reg_wdata,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic              irq
);
    localparam int PAD_W = CNT_W - WORD_W;

    logic [WORD_W-1:0] freq_q, kword_q, rel_view;
    logic [CNT_W-1:0]  cnt_eff, cmp_q;
    logic              en_q, mask_q, status_q;
    logic              wr_freq, wr_kword, wr_ctrl, ld_abs, ld_rel;

    // decode write strobes; count and unused indices have no target
    always_comb begin
        wr_freq  = reg_wr && (reg_addr == IDX_FREQ);
        wr_kword = reg_wr && (reg_addr == IDX_KWORD);
        wr_ctrl  = reg_wr && (reg_addr == IDX_CTRL);
        ld_abs   = reg_wr && (reg_addr == IDX_CMP);
        ld_rel   = reg_wr && (reg_addr == IDX_REL);
    end

    tmr_ctrl_regs #(.FW(WORD_W), .FREQ_INIT(FREQ_RESET)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_freq(wr_freq), .wr_kword(wr_kword), .wr_ctrl(wr_ctrl),
        .wdata(reg_wdata[WORD_W-1:0]),
        .freq_q(freq_q), .kword_q(kword_q), .en_q(en_q), .mask_q(mask_q)
    );

    tmr_count_view #(.CW(CNT_W), .FW(WORD_W)) u_view (
        .freq(freq_q), .sys_count(sys_count), .cnt(cnt_eff)
    );

    tmr_compare #(.CW(CNT_W), .RW(WORD_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt_eff),
        .ld_abs(ld_abs), .ld_rel(ld_rel), .wdata(reg_wdata),
        .cmp_q(cmp_q), .status_q(status_q), .rel_view(rel_view)
    );

    // read multiplexer; unknown indices return zero
    always_comb begin
        case (reg_addr)
            IDX_FREQ:  reg_rdata = {{PAD_W{1'b0}}, freq_q};
            IDX_KWORD: reg_rdata = {{PAD_W{1'b0}}, kword_q};
            IDX_COUNT: reg_rdata = cnt_eff;
            IDX_CMP:   reg_rdata = cmp_q;
            IDX_REL:   reg_rdata = {{PAD_W{1'b0}}, rel_view};
            IDX_CTRL:  reg_rdata = {{(CNT_W-3){1'b0}}, status_q, mask_q, en_q};
            default:   reg_rdata = '0;
        endcase
    end

    // level interrupt gated by enable and mask
    always_comb begin
        irq = status_q & en_q & ~mask_q;
    end
endmodule

// File: rtl/tmr_checker.sv
// Property checker for percore_cmp_timer, attached with bind below.
module tmr_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  reg_addr,
    input logic        reg_wr,
    input logic [63:0] reg_wdata,
    input logic [63:0] reg_rdata,
    input logic        irq,
    input logic [63:0] cnt_eff,
    input logic [31:0] freq_q,
    input logic        status_q,
    input logic        en_q,
    input logic        mask_q
);
    logic cmp_load;
    assign cmp_load = reg_wr && (reg_addr == 4'd3 || reg_addr == 4'd4);

    assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q || mask_q || !status_q) |-> !irq);

    assert_status_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q && !cmp_load) |=> status_q);

    assert_abs_reeval_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 4'd3) |=> (status_q == $past(cnt_eff >= reg_wdata)));

    assert_count_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'd2) |-> (reg_rdata == cnt_eff));

    assert_zero_freq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_q == 32'd0) |-> (cnt_eff == 64'd0));

    assert_ctrl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 4'd5) |-> (reg_rdata[63:3] == '0));

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr > 4'd5) |-> (reg_rdata == 64'd0));
endmodule

bind percore_cmp_timer tmr_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .cnt_eff(cnt_eff), .freq_q(freq_q), .status_q(status_q),
    .en_q(en_q), .mask_q(mask_q)
);

// File: tb/sim_percore_cmp_timer.sv
// Bench: behavioural model updated per edge, compared against the ports every cycle.
module sim_percore_cmp_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_count = 64'd0;
    logic [3:0]  reg_addr = 4'd0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = 64'd0;
    logic [63:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit armed = 1'b0;
    bit done  = 1'b0;

    // model state
    logic [31:0] m_freq, m_kw;
    logic [63:0] m_cmp;
    logic        m_en, m_mask, m_st;

    percore_cmp_timer u0 (
        .clk(clk), .rst_n(rst_n), .sys_count(sys_count), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [63:0] gcnt();
        return (m_freq == 32'd0) ? 64'd0 : sys_count;
    endfunction

    // model update on each rising edge from pre-edge inputs
    always @(posedge clk) begin
        logic [63:0] c, ncmp;
        bit ld;
        c = gcnt();
        if (!rst_n) begin
            m_freq = 32'h0180_0000; m_kw = 0; m_cmp = 0;
            m_en = 0; m_mask = 0; m_st = 0; armed = 1'b1;
        end else begin
            ld = 0; ncmp = m_cmp;
            if (reg_wr) begin
                case (reg_addr)
                    4'd0: m_freq = reg_wdata[31:0];
                    4'd1: m_kw   = reg_wdata[31:0];
                    4'd3: begin ncmp = reg_wdata; ld = 1; end
                    4'd4: begin ncmp = c + {{32{reg_wdata[31]}}, reg_wdata[31:0]}; ld = 1; end
                    4'd5: begin m_en = reg_wdata[0]; m_mask = reg_wdata[1]; end
                    default: ;
                endcase
            end
            if (ld) begin m_st = (c >= ncmp); m_cmp = ncmp; end
            else m_st = m_st | (c >= m_cmp);
        end
    end

    task automatic check_now();
        logic [63:0] exp;
        logic [63:0] d;
        string tag;
        if (!armed) return;
        d = m_cmp - gcnt();
        case (reg_addr)
            4'd0: begin exp = {32'd0, m_freq}; tag = "R9"; end
            4'd1: begin exp = {32'd0, m_kw}; tag = "R11"; end
            4'd2: begin exp = gcnt(); tag = "R8"; end
            4'd3: begin exp = m_cmp; tag = "R4/R5"; end
            4'd4: begin exp = {32'd0, d[31:0]}; tag = "R6"; end
            4'd5: begin exp = {61'd0, m_st, m_mask, m_en}; tag = "R2/R3"; end
            default: begin exp = 64'd0; tag = "R10"; end
        endcase
        if (!rst_n) tag = "R1";
        n_chk++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%0d rdata=%h expected=%h", tag, reg_addr, reg_rdata, exp);
        end
        n_chk++;
        if (irq !== (m_st & m_en & ~m_mask)) begin
            n_bad++;
            $display("FAIL R7 irq=%b expected=%b", irq, m_st & m_en & ~m_mask);
        end
    endtask

    // one cycle: drive at falling edge, count advances, check before next rise
    task automatic step(input logic [3:0] a, input bit w, input logic [63:0] d);
        @(negedge clk);
        reg_addr = a; reg_wr = w; reg_wdata = d;
        sys_count = sys_count + 64'd1;
        #(CLK_PERIOD/4);
        check_now();
    endtask

    task automatic rd(input logic [3:0] a); step(a, 1'b0, 64'd0); endtask
    task automatic wr(input logic [3:0] a, input logic [63:0] d); step(a, 1'b1, d); endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) rd(4'd5);
    endtask

    initial begin
        sys_count = 64'd100;
        // R1: reset state
        for (int i = 0; i < 3; i++) rd(4'd5);
        rd(4'd0); rd(4'd3);
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 16; a++) rd(a[3:0]);
        // R3: status latches with timer disabled, cmp=0 already met
        idle(2);
        // R4: absolute compare ahead, then behind, then equal at the write edge
        wr(4'd3, sys_count + 64'd10); idle(3); rd(4'd3);
        wr(4'd5, 64'd1); idle(12);                        // R7 rises when reached
        wr(4'd5, 64'd3); idle(2);                         // mask: R7 falls
        wr(4'd5, 64'hFF); idle(2);                        // R2: bit 2 write ignored
        wr(4'd3, sys_count + 64'd1); idle(1);             // equal at edge
        wr(4'd3, sys_count + 64'd2); idle(3);
        wr(4'd3, sys_count - 64'd5); idle(2);
        wr(4'd3, 64'hFFFF_FFFF_FFFF_FFF0); idle(2);       // far ahead, status clears
        // R5: relative writes, positive and negative
        wr(4'd4, 64'd6); rd(4'd4); rd(4'd4); idle(8);
        wr(4'd4, 64'hDEAD_BEEF_FFFF_FFFD); rd(4'd3); rd(4'd4); idle(2);
        wr(4'd4, 64'h0000_0000_7FFF_FFFF); rd(4'd4); rd(4'd3);
        wr(4'd5, 64'd0); rd(4'd5);                        // disable: R7 low
        // R8: count read-only
        wr(4'd2, 64'h1234); rd(4'd2); rd(4'd3);
        // R10: unused indices
        for (int a = 6; a < 16; a++) wr(a[3:0], 64'hFFFF_FFFF_FFFF_FFFF);
        for (int a = 0; a < 16; a++) rd(a[3:0]);
        // R11: kernel word
        wr(4'd1, 64'hAAAA_5555_1234_5678); rd(4'd1);
        // R9: zero frequency gates the count, in the same cycle as a compare rewrite
        wr(4'd3, sys_count + 64'd50); wr(4'd5, 64'd1);
        wr(4'd0, 64'd0); rd(4'd2); rd(4'd4);
        wr(4'd3, 64'd0); idle(3);                         // gated count 0 >= 0
        wr(4'd4, 64'hFFFF_FFFF); rd(4'd3); idle(2);
        wr(4'd0, 64'hFFFF_FFFF_0000_0007); rd(4'd0); rd(4'd2); idle(2);
        // count near wrap
        @(negedge clk); sys_count = 64'hFFFF_FFFF_FFFF_FFF8;
        wr(4'd3, 64'hFFFF_FFFF_FFFF_FFFE); idle(6); rd(4'd4);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    // watchdog: a hung run counts as one failed check
    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule